// File: doc/BRIEF.md
# Registered 12/24-bit Bus Exchanger

This block joins a narrow 12-bit port (side A) to a wide 24-bit port (side B). Side B is treated as two 12-bit halves, a low half and a high half, each backed by its own register. Each half copies the side-A input on a rising clock edge while its own active-low load enable is asserted. By loading one narrow word into the low half and a following word into the high half, a pair of consecutive narrow transfers is assembled into a single wide word.

Traffic from B to A goes through one register that captures either the low or the high half of the side-B input on every clock edge. The half-select input and the three active-low drive enables are themselves captured on the clock. A change on any of them therefore shows up at the outputs only after the following rising edge. Each tri-state pin group is modelled as an input bus, an output bus and a drive-enable output. A synchronous active-low reset clears every data register and turns every drive off.

Top module: `bxch_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the drive outputs `a_drv`, `blo_drv` and `bhi_drv` are 0 after that edge, and `a_out` and `b_out` are all zeros.
- R2: At a rising edge with `ld_lo_n` low, `b_out[11:0]` takes the value of `a_in`. With `ld_lo_n` high, `b_out[11:0]` keeps its value.
- R3: At a rising edge with `ld_hi_n` low, `b_out[23:12]` takes the value of `a_in`. With `ld_hi_n` high, `b_out[23:12]` keeps its value.
- R4: When both load enables are low at the same edge, both halves of `b_out` take the same `a_in` word.
- R5: If word X is loaded into the low half at one edge and word Y into the high half at a later edge, with no other load in between, `b_out` then reads {Y, X}.
- R6: After each rising edge, `a_out` holds the side-B half selected by the registered select: `b_in[11:0]` when it is 0 and `b_in[23:12]` when it is 1. The `b_in` value used is the one sampled at that edge.
- R7: A change of `sel` seen at edge k first affects the capture made at edge k+1. The capture at edge k still uses the select value registered at the edge before it.
- R8: After each rising edge, `a_drv`, `blo_drv` and `bhi_drv` equal the inverse of `oe_a_n`, `oe_blo_n` and `oe_bhi_n` as sampled at that edge. They do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 12 | Narrow-side input data |
| b_in | input | 24 | Wide-side input data; [11:0] is the low half, [23:12] the high half |
| ld_lo_n | input | 1 | Active-low load enable for the low half register |
| ld_hi_n | input | 1 | Active-low load enable for the high half register |
| sel | input | 1 | Half select for B-to-A (0 low, 1 high), registered |
| oe_a_n | input | 1 | Active-low drive enable for the narrow side, registered |
| oe_blo_n | input | 1 | Active-low drive enable for the low half, registered |
| oe_bhi_n | input | 1 | Active-low drive enable for the high half, registered |
| a_out | output | 12 | Registered narrow-side output data |
| a_drv | output | 1 | Narrow-side drive enable |
| b_out | output | 24 | Registered wide-side output data |
| blo_drv | output | 1 | Low-half drive enable |
| bhi_drv | output | 1 | High-half drive enable |

## Verification
The case that is hardest to reach is the select input toggling at the very edge where `b_in` also changes. The capture then has to follow the old select while taking the new data, and a design with the select pipelined one stage wrong still passes steady-select traffic. The stimulus forces this with a directed sequence that holds distinct values in the two halves and flips `sel` on one edge. It then runs long stretches where `sel`, `b_in`, both load enables and all three drive enables change at random on the same edges, including edges where both loads fire together.

// File: rtl/bxch_pkg.sv
// Package: shared widths and types for the bus exchanger.
// Assumes the wide side is exactly two narrow halves.
package bxch_pkg;
    parameter int HALF_W = 12;
    localparam int WIDE_W = 2 * HALF_W;
    localparam int NUM_HALVES = 2;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WIDE_W-1:0] wide_t;

    // Registered control set captured every edge.
    typedef struct packed {
        logic sel;
        logic oe_a_n;
        logic oe_blo_n;
        logic oe_bhi_n;
    } ctrl_t;
endpackage

// File: rtl/bxch_half_reg.sv
// Module: one half of the wide-side register.
// Loads the narrow input on a rising edge while ld_n is low and holds
// otherwise. Assumes synchronous active-low reset clears it to zero.
module bxch_half_reg
    import bxch_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: capture d when the active-low load enable is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!ld_n)
            q <= d;
    end

    // R2 R3: a load copies the input, no load keeps the value.
    p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> (q == $past(d)));
    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(q));
endmodule

// File: rtl/bxch_ctrl_reg.sv
// Module: control capture stage.
// Registers the half select and the three active-low drive enables so
// every output behaviour changes only at a clock edge. Reset selects the
// low half and turns all drives off.
module bxch_ctrl_reg
    import bxch_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_in,
    output ctrl_t ctrl_q
);
    localparam ctrl_t CTRL_RST = '{sel: 1'b0, oe_a_n: 1'b1, oe_blo_n: 1'b1, oe_bhi_n: 1'b1};

    // Purpose: sample all controls each edge, reset to drives-off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else
            ctrl_q <= ctrl_in;
    end

    // R8: registered enables reflect the previous sampled inputs.
    p_oe_sampled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctrl_q.oe_a_n == $past(ctrl_in.oe_a_n)));
endmodule

// File: rtl/bxch_a_path.sv
// Module: wide-to-narrow storage register.
// Captures on every rising edge the half of b_in chosen by the already
// registered select (0 low half, 1 high half). Assumes sel_q comes from
// the control stage so a select change lands one edge later.
module bxch_a_path
    import bxch_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_q,
    input  logic [2*W-1:0] b_in,
    output logic [W-1:0]   q
);
    logic [W-1:0] pick;

    // Purpose: choose the half to be captured.
    always_comb begin
        pick = sel_q ? b_in[2*W-1:W] : b_in[W-1:0];
    end

    // Purpose: storage register that feeds the narrow-side output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= pick;
    end

    // R6: capture follows the registered select.
    p_low_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |=> (q == $past(b_in[W-1:0])));
    p_high_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |=> (q == $past(b_in[2*W-1:W])));
endmodule

// File: rtl/bxch_top.sv
// Module: registered 12/24-bit bus exchanger top.
// Packs two narrow words into a wide word through two independently
// enabled half registers, and returns a selected half through one
// register. Drive enables are registered active-low controls, inverted.
// Assumes a synchronous active-low reset is applied before use.
module bxch_top
    import bxch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] a_in,
    input  logic [23:0] b_in,
    input  logic        ld_lo_n,
    input  logic        ld_hi_n,
    input  logic        sel,
    input  logic        oe_a_n,
    input  logic        oe_blo_n,
    input  logic        oe_bhi_n,
    output logic [11:0] a_out,
    output logic        a_drv,
    output logic [23:0] b_out,
    output logic        blo_drv,
    output logic        bhi_drv
);
    ctrl_t ctrl_in;
    ctrl_t ctrl_q;
    logic [NUM_HALVES-1:0] ld_n_vec;

    // Purpose: gather controls for the capture stage.
    always_comb begin
        ctrl_in.sel      = sel;
        ctrl_in.oe_a_n   = oe_a_n;
        ctrl_in.oe_blo_n = oe_blo_n;
        ctrl_in.oe_bhi_n = oe_bhi_n;
        ld_n_vec         = {ld_hi_n, ld_lo_n};
    end

    bxch_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_in (ctrl_in),
        .ctrl_q  (ctrl_q)
    );

    // One register per wide-side half, index 0 is the low half.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        bxch_half_reg #(.W(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_n  (ld_n_vec[h]),
            .d     (a_in),
            .q     (b_out[h*HALF_W +: HALF_W])
        );
    end

    bxch_a_path #(.W(HALF_W)) u_apath (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_q (ctrl_q.sel),
        .b_in  (b_in),
        .q     (a_out)
    );

    // Purpose: drive enables are the inverse of the registered active-low controls.
    always_comb begin
        a_drv   = ~ctrl_q.oe_a_n;
        blo_drv = ~ctrl_q.oe_blo_n;
        bhi_drv = ~ctrl_q.oe_bhi_n;
    end

    // R4: a joint load leaves both halves equal.
    p_joint_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_lo_n && !ld_hi_n) |=> (b_out[11:0] == b_out[23:12]));
    // R8: drives follow the sampled enables of the previous edge.
    p_blo_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (blo_drv == !$past(oe_blo_n)));
    p_bhi_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bhi_drv == !$past(oe_bhi_n)));
endmodule

// File: tb/bxch_top_tb_top.sv
// Bench: behavioural cycle model compared on every falling edge,
// plus directed sequences for packing, select timing and reset.
module bxch_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic clk = 1'b0;
    logic rst_n;
    logic [11:0] a_in;
    logic [23:0] b_in;
    logic ld_lo_n, ld_hi_n, sel, oe_a_n, oe_blo_n, oe_bhi_n;
    logic [11:0] a_out;
    logic a_drv, blo_drv, bhi_drv;
    logic [23:0] b_out;

    int checks = 0;
    int fails = 0;
    bit chk_en = 0;
    bit done = 0;

    // Reference state
    int m_lo, m_hi, m_a, m_sel;
    bit m_da, m_dlo, m_dhi;

    always #(CLK_PERIOD/2) clk = ~clk;

    bxch_top dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ld_lo_n(ld_lo_n), .ld_hi_n(ld_hi_n), .sel(sel),
        .oe_a_n(oe_a_n), .oe_blo_n(oe_blo_n), .oe_bhi_n(oe_bhi_n),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out),
        .blo_drv(blo_drv), .bhi_drv(bhi_drv)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_a = 0; m_sel = 0;
            m_da = 0; m_dlo = 0; m_dhi = 0;
        end else begin
            m_a = (m_sel != 0) ? int'(b_in[23:12]) : int'(b_in[11:0]);
            if (!ld_lo_n) m_lo = int'(a_in);
            if (!ld_hi_n) m_hi = int'(a_in);
            m_sel = int'(sel);
            m_da = !oe_a_n; m_dlo = !oe_blo_n; m_dhi = !oe_bhi_n;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            check("R6 R7 a_out", int'(a_out), m_a);
            check("R2 R4 b_out low", int'(b_out[11:0]), m_lo);
            check("R3 R4 b_out high", int'(b_out[23:12]), m_hi);
            check("R8 a_drv", int'(a_drv), int'(m_da));
            check("R8 blo_drv", int'(blo_drv), int'(m_dlo));
            check("R8 bhi_drv", int'(bhi_drv), int'(m_dhi));
        end
    end

    task automatic cyc(); @(negedge clk); endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; a_in = '0; b_in = '0; ld_lo_n = 1; ld_hi_n = 1; sel = 0;
        oe_a_n = 0; oe_blo_n = 0; oe_bhi_n = 0;
        cyc(); cyc();
        // R1: reset state even with enables requested low
        check("R1 a_drv", int'(a_drv), 0);
        check("R1 blo_drv", int'(blo_drv), 0);
        check("R1 bhi_drv", int'(bhi_drv), 0);
        check("R1 a_out", int'(a_out), 0);
        check("R1 b_out", int'(b_out), 0);
        rst_n = 1; chk_en = 1;

        // R5: pack two consecutive words
        a_in = 12'hABC; ld_lo_n = 0; cyc();
        a_in = 12'h123; ld_lo_n = 1; ld_hi_n = 0; cyc();
        ld_hi_n = 1; a_in = 12'hFFF; cyc();
        check("R5 packed", int'(b_out), int'(24'h123ABC));
        // R2 R3: loads disabled, halves held
        cyc();
        check("R2 R3 hold", int'(b_out), int'(24'h123ABC));
        // R4: joint load
        a_in = 12'h5A5; ld_lo_n = 0; ld_hi_n = 0; cyc();
        ld_lo_n = 1; ld_hi_n = 1;
        check("R4 joint", int'(b_out), int'(24'h5A55A5));

        // R7: select flips on the same edge as new data
        b_in = 24'h2B21B1; sel = 0; cyc();
        sel = 1; b_in = 24'h4D43C3; cyc();
        check("R7 old select used", int'(a_out), int'(12'h3C3));
        cyc();
        check("R7 new select used", int'(a_out), int'(12'h4D4));

        // R8: drive enables toggle through the register
        oe_a_n = 1; oe_blo_n = 0; oe_bhi_n = 1; cyc();
        check("R8 a off", int'(a_drv), 0);
        check("R8 blo on", int'(blo_drv), 1);
        check("R8 bhi off", int'(bhi_drv), 0);

        // Random traffic
        for (int i = 0; i < 2000; i++) begin
            a_in = 12'($urandom); b_in = 24'($urandom);
            ld_lo_n = 1'($urandom); ld_hi_n = 1'($urandom); sel = 1'($urandom);
            oe_a_n = 1'($urandom); oe_blo_n = 1'($urandom); oe_bhi_n = 1'($urandom);
            cyc();
        end

        // R1: reset mid-run
        rst_n = 0; cyc();
        chk_en = 0;
        check("R1 re-reset drives", int'({a_drv, blo_drv, bhi_drv}), 0);
        check("R1 re-reset data", int'(b_out), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule